// File: doc/BRIEF.md
# Decode-Resolved Branch Fetch Controller

This block owns the fetch address and the fetch/decode pipeline register of a five-stage in-order pipeline. Every branch is settled in the decode stage, which gives both the outcome and the byte target. Fetch always follows the sequential path, so every branch is in effect predicted not taken.

A not-taken branch costs nothing. For a taken branch, the fetch address jumps to the target on the clock edge at which decode reports the branch. Since the decision happens in decode, one wrong-path instruction has already been fetched. In the default mode that instruction is replaced by an invalid bubble, which costs one cycle. When the `DELAY_SLOT` parameter is set, that one instruction is instead passed on as valid and always commits.

A stall input from the rest of the hazard logic freezes both the fetch address and the pipeline register. A redirect that arrives during a stall is remembered and applied on the first cycle after the stall ends. The instruction memory is read combinationally at the presented fetch address.

Top module: `brf_fetch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes `RESET_VEC`, `ifid_valid_o` becomes 0, `ifid_instr_o` becomes `BUBBLE_WORD` and `ifid_pc_o` becomes `RESET_VEC`.
- R2: In an unstalled cycle with no redirect, the fetch address advances by `INSTR_W/8` (4 by default). The pipeline register captures valid=1, the fetched word and the fetch address of that cycle.
- R3: With `DELAY_SLOT`=0, an unstalled cycle with `br_valid_i`=1 and `br_taken_i`=1 loads `br_target_i` into the fetch address. In the same edge it loads the pipeline register with valid=0, `BUBBLE_WORD` and the squashed instruction's fetch address.
- R4: A branch with `br_valid_i`=1 and `br_taken_i`=0 behaves exactly like a sequential cycle (R2), with no bubble and no change of path.
- R5: With `DELAY_SLOT`=1, a taken branch loads the target into the fetch address, and the instruction fetched in that cycle is captured with valid=1.
- R6: While `stall_i`=1, the fetch address and all three pipeline-register outputs hold their values.
- R7: A taken branch presented while `stall_i`=1 is kept. On the first cycle with `stall_i`=0 it is applied as in R3/R5, even if decode no longer presents it. If several taken branches arrive during one stall, the last target wins.
- R8: On the cycle a stall releases, a taken branch presented in that same cycle takes precedence over a kept one.
- R9: `br_taken_i` and `br_target_i` have no effect while `br_valid_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze fetch address and pipeline register |
| br_valid_i | input | 1 | Decode holds a branch this cycle |
| br_taken_i | input | 1 | Resolved outcome, 1 = taken |
| br_target_i | input | ADDR_W | Resolved byte target |
| fetch_instr_i | input | INSTR_W | Word read at `fetch_pc_o` |
| fetch_pc_o | output | ADDR_W | Registered fetch address |
| ifid_valid_o | output | 1 | Pipeline register holds a live instruction |
| ifid_instr_o | output | INSTR_W | Instruction handed to decode |
| ifid_pc_o | output | ADDR_W | Fetch address of that instruction |

## Verification
The stall and the redirect can land in the same cycle, and so can a remembered redirect and a fresh one on the cycle a stall releases. The bench forces both cases. It raises a taken branch under stall and then drops it, and it presents a second taken branch with a different target on the release cycle. A behavioural model then decides which target must appear and whether a bubble or a delay-slot instruction follows. It does this for a squashing instance and a delay-slot instance driven side by side.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [1:0] {
    NPC_HOLD  = 2'd0,
    NPC_SEQ   = 2'd1,
    NPC_REDIR = 2'd2
  } npc_sel_e;

  typedef enum logic [1:0] {
    IFID_HOLD   = 2'd0,
    IFID_LOAD   = 2'd1,
    IFID_BUBBLE = 2'd2
  } ifid_op_e;
endpackage

// File: rtl/brf_redirect_hold.sv
module brf_redirect_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              req,
  input  logic [ADDR_W-1:0] tgt,
  output logic              eff_req,
  output logic [ADDR_W-1:0] eff_tgt
);
  logic              pend_q;
  logic [ADDR_W-1:0] ptgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ptgt_q <= '0;
    end else if (stall) begin
      if (req) begin
        pend_q <= 1'b1;
        ptgt_q <= tgt;
      end
    end else begin
      pend_q <= 1'b0;
    end
  end

  // fresh request from decode wins over a remembered one
  always_comb begin
    eff_req = req | pend_q;
    eff_tgt = req ? tgt : ptgt_q;
  end
endmodule

// File: rtl/brf_next_pc_ctrl.sv
module brf_next_pc_ctrl
  import brf_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic     stall,
  input  logic     eff_req,
  output npc_sel_e npc_sel,
  output ifid_op_e ifid_op
);
  ifid_op_e redir_op;

  generate
    if (DELAY_SLOT) begin : g_slot
      assign redir_op = IFID_LOAD;
    end else begin : g_squash
      assign redir_op = IFID_BUBBLE;
    end
  endgenerate

  always_comb begin
    if (stall) begin
      npc_sel = NPC_HOLD;
      ifid_op = IFID_HOLD;
    end else if (eff_req) begin
      npc_sel = NPC_REDIR;
      ifid_op = redir_op;
    end else begin
      npc_sel = NPC_SEQ;
      ifid_op = IFID_LOAD;
    end
  end
endmodule

// File: rtl/brf_pc_reg.sv
module brf_pc_reg
  import brf_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter int              STEP      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  npc_sel_e          sel,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_next;

  always_comb begin
    unique case (sel)
      NPC_SEQ:   pc_next = pc + ADDR_W'(STEP);
      NPC_REDIR: pc_next = tgt;
      default:   pc_next = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_VEC;
    else     pc <= pc_next;
  end
endmodule

// File: rtl/brf_ifid_reg.sv
module brf_ifid_reg
  import brf_pkg::*;
#(
  parameter int                 ADDR_W      = 32,
  parameter int                 INSTR_W     = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC   = '0,
  parameter logic [INSTR_W-1:0] BUBBLE_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  ifid_op_e           op,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  pc,
  output logic               valid_q,
  output logic [INSTR_W-1:0] instr_q,
  output logic [ADDR_W-1:0]  pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      instr_q <= BUBBLE_WORD;
      pc_q    <= RESET_VEC;
    end else begin
      unique case (op)
        IFID_LOAD: begin
          valid_q <= 1'b1;
          instr_q <= instr;
          pc_q    <= pc;
        end
        IFID_BUBBLE: begin
          valid_q <= 1'b0;
          instr_q <= BUBBLE_WORD;
          pc_q    <= pc;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brf_fetch_ctrl.sv
module brf_fetch_ctrl
  import brf_pkg::*;
#(
  parameter int                 ADDR_W      = 32,
  parameter int                 INSTR_W     = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC   = ADDR_W'('h100),
  parameter logic [INSTR_W-1:0] BUBBLE_WORD = '0,
  parameter bit                 DELAY_SLOT  = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall_i,
  input  logic               br_valid_i,
  input  logic               br_taken_i,
  input  logic [ADDR_W-1:0]  br_target_i,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic               ifid_valid_o,
  output logic [INSTR_W-1:0] ifid_instr_o,
  output logic [ADDR_W-1:0]  ifid_pc_o
);
  localparam int STEP = INSTR_W / 8;

  logic              redir_req;
  logic              eff_req;
  logic [ADDR_W-1:0] eff_tgt;
  npc_sel_e          npc_sel;
  ifid_op_e          ifid_op;

  assign redir_req = br_valid_i & br_taken_i;

  brf_redirect_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall_i),
    .req     (redir_req),
    .tgt     (br_target_i),
    .eff_req (eff_req),
    .eff_tgt (eff_tgt)
  );

  brf_next_pc_ctrl #(.DELAY_SLOT(DELAY_SLOT)) u_ctrl (
    .stall   (stall_i),
    .eff_req (eff_req),
    .npc_sel (npc_sel),
    .ifid_op (ifid_op)
  );

  brf_pc_reg #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .STEP      (STEP)
  ) u_pc (
    .clk (clk),
    .rst (rst),
    .sel (npc_sel),
    .tgt (eff_tgt),
    .pc  (fetch_pc_o)
  );

  brf_ifid_reg #(
    .ADDR_W      (ADDR_W),
    .INSTR_W     (INSTR_W),
    .RESET_VEC   (RESET_VEC),
    .BUBBLE_WORD (BUBBLE_WORD)
  ) u_ifid (
    .clk     (clk),
    .rst     (rst),
    .op      (ifid_op),
    .instr   (fetch_instr_i),
    .pc      (fetch_pc_o),
    .valid_q (ifid_valid_o),
    .instr_q (ifid_instr_o),
    .pc_q    (ifid_pc_o)
  );
endmodule

// File: rtl/brf_fetch_chk.sv
module brf_fetch_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                INSTR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC  = '0,
  parameter bit                DELAY_SLOT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              br_valid_i,
  input logic              br_taken_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              ifid_valid_o,
  input logic [ADDR_W-1:0] ifid_pc_o
);
  localparam int STEP = INSTR_W / 8;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (fetch_pc_o == RESET_VEC && !ifid_valid_o)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !$past(stall_i) && !(br_valid_i && br_taken_i))
      |=> (fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(STEP))); // R2

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && br_taken_i) |=> (fetch_pc_o == $past(br_target_i))); // R3

  AST_NT_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && br_valid_i && !br_taken_i && !$past(stall_i)) |=> ifid_valid_o); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(fetch_pc_o) && $stable(ifid_valid_o) && $stable(ifid_pc_o))); // R6

  generate
    if (DELAY_SLOT) begin : g_slot
      AST_SLOT_COMMITS: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && br_valid_i && br_taken_i) |=> ifid_valid_o); // R5
    end else begin : g_squash
      AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && br_valid_i && br_taken_i) |=> !ifid_valid_o); // R3
    end
  endgenerate
endmodule

bind brf_fetch_ctrl brf_fetch_chk #(
  .ADDR_W     (ADDR_W),
  .INSTR_W    (INSTR_W),
  .RESET_VEC  (RESET_VEC),
  .DELAY_SLOT (DELAY_SLOT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stall_i      (stall_i),
  .br_valid_i   (br_valid_i),
  .br_taken_i   (br_taken_i),
  .br_target_i  (br_target_i),
  .fetch_pc_o   (fetch_pc_o),
  .ifid_valid_o (ifid_valid_o),
  .ifid_pc_o    (ifid_pc_o)
);

// File: tb/brf_fetch_ctrl_test.sv
module brf_fetch_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RVEC = 32'h0000_0100;
  localparam logic [31:0] BUB  = 32'h0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0, bv = 1'b0, bt = 1'b0;
  logic [31:0] btgt = '0;

  logic [31:0] pc0, pc1, ins0, ins1, ipc0, ipc1, iin0, iin1;
  logic v0, v1;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] imem(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
  endfunction

  assign ins0 = imem(pc0);
  assign ins1 = imem(pc1);

  brf_fetch_ctrl #(.DELAY_SLOT(1'b0)) uut (
    .clk(clk), .rst(rst), .stall_i(stall), .br_valid_i(bv), .br_taken_i(bt),
    .br_target_i(btgt), .fetch_instr_i(ins0), .fetch_pc_o(pc0),
    .ifid_valid_o(v0), .ifid_instr_o(iin0), .ifid_pc_o(ipc0));

  brf_fetch_ctrl #(.DELAY_SLOT(1'b1)) uut_ds (
    .clk(clk), .rst(rst), .stall_i(stall), .br_valid_i(bv), .br_taken_i(bt),
    .br_target_i(btgt), .fetch_instr_i(ins1), .fetch_pc_o(pc1),
    .ifid_valid_o(v1), .ifid_instr_o(iin1), .ifid_pc_o(ipc1));

  // behavioural model, index 0 = squash, 1 = delay slot
  logic [31:0] m_pc[2], m_ins[2], m_ipc[2], m_ptgt[2];
  bit          m_v[2], m_pend[2];

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      m_pc[m] = RVEC; m_v[m] = 0; m_ins[m] = BUB; m_ipc[m] = RVEC; m_pend[m] = 0;
    end
  endtask

  task automatic model_step(input bit s, input bit v, input bit t, input logic [31:0] tg);
    for (int m = 0; m < 2; m++) begin
      bit fresh;
      fresh = v && t;
      if (s) begin
        if (fresh) begin m_pend[m] = 1; m_ptgt[m] = tg; end
      end else if (fresh || m_pend[m]) begin
        m_ipc[m] = m_pc[m];
        if (m == 0) begin m_v[m] = 0; m_ins[m] = BUB; end
        else        begin m_v[m] = 1; m_ins[m] = imem(m_pc[m]); end
        m_pc[m]   = fresh ? tg : m_ptgt[m];
        m_pend[m] = 0;
      end else begin
        m_ipc[m] = m_pc[m];
        m_v[m]   = 1;
        m_ins[m] = imem(m_pc[m]);
        m_pc[m]  = m_pc[m] + 32'd4;
      end
    end
  endtask

  task automatic cmp1(input string tag, input string who,
                      input logic [31:0] apc, input bit av, input logic [31:0] ain,
                      input logic [31:0] aipc, input int m);
    vectors++;
    if (apc !== m_pc[m] || av !== m_v[m] || ain !== m_ins[m] || aipc !== m_ipc[m]) begin
      fails++;
      $display("FAIL %s %s: got pc=%h v=%0b ins=%h ipc=%h expected pc=%h v=%0b ins=%h ipc=%h",
               tag, who, apc, av, ain, aipc, m_pc[m], m_v[m], m_ins[m], m_ipc[m]);
    end
  endtask

  task automatic compare(input string tag);
    cmp1(tag, "squash", pc0, v0, iin0, ipc0, 0);
    cmp1(tag, "slot",   pc1, v1, iin1, ipc1, 1);
  endtask

  task automatic step(input bit s, input bit v, input bit t, input logic [31:0] tg,
                      input string tag);
    stall = s; bv = v; bt = t; btgt = tg;
    model_step(s, v, t, tg);
    @(posedge clk); #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; stall = 0; bv = 0; bt = 0;
    model_reset();
    repeat (n) @(posedge clk);
    #1 compare("R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion expected finish within 5000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(2);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 32'h0, "R2");
    step(0, 1, 0, 32'hDEAD_0000, "R4");          // not taken, no bubble
    step(0, 0, 0, 32'h0, "R4");
    step(0, 1, 1, 32'h0000_2000, "R3_R5");       // taken
    step(0, 0, 0, 32'h0, "R2");
    step(0, 0, 0, 32'h0, "R2");
    step(0, 0, 1, 32'h0000_7000, "R9");          // taken flag without valid
    step(0, 0, 1, 32'h0000_7100, "R9");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 32'h0, "R6");
    step(1, 1, 1, 32'h0000_3000, "R7");          // redirect under stall
    step(1, 0, 0, 32'h0, "R7");
    step(0, 0, 0, 32'h0, "R7");                  // applied on release
    step(0, 0, 0, 32'h0, "R7");
    step(1, 1, 1, 32'h0000_3800, "R7");          // two during one stall
    step(1, 1, 1, 32'h0000_3C00, "R7");
    step(0, 0, 0, 32'h0, "R7");
    step(1, 1, 1, 32'h0000_4000, "R8");
    step(0, 1, 1, 32'h0000_5000, "R8");          // fresh wins on release
    step(0, 0, 0, 32'h0, "R8");
    step(0, 1, 1, 32'h0000_6000, "R3_R5");       // back-to-back taken
    step(0, 1, 1, 32'h0000_6100, "R3_R5");
    step(0, 0, 0, 32'h0, "R2");
    step(1, 1, 0, 32'h0000_AAAA, "R6");          // not taken under stall
    step(0, 0, 0, 32'h0, "R4");
    do_reset(1);
    for (int i = 0; i < 60; i++) begin
      bit s, v, t;
      s = (i % 5) == 3;
      v = (i % 3) == 0;
      t = (i % 4) != 1;
      step(s, v, t, 32'h0000_8000 + 32'(i) * 32'h40, "R2_R3_R6_R7");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule